// File: doc/BRIEF.md
# Paired-Decoder Programmable Logic Array

This block is a small programmable logic array in which the binary inputs are taken two at a time. Each pair drives a 2-to-4 decoder. The decoder produces four columns, and each column is a two-input OR of the pair's literals. Each pair therefore acts as one four-valued variable. Each column is true for three of the four values and false for the one value it excludes. Product terms AND together any chosen set of columns, and an OR plane gathers terms into binary outputs.

Because a single decoded column already covers three values of a pair, functions such as the equivalence of two inputs need two columns of one pair inside a single product term. A plain array would need two terms built from true and complemented literals. Both planes are programmed through a synchronous write port. The logic path from the data inputs to the outputs is combinational unless the registered-output variant is chosen.

Top module: `pairdec_pla`

## Requirements
- R1: Pair p is formed from `din[2p+1]` (called a, the high bit) and `din[2p]` (called b), and its four-valued value is X = 2a+b.
- R2: Decoder column index 4p+k (k = 0..3) is 1 exactly when X of pair p differs from k. So k=0 is a|b, k=1 is a|~b, k=2 is ~a|b and k=3 is ~a|~b. Exactly three of a pair's four columns are 1.
- R3: Product term t is the AND of every column c whose mask bit `cfg_and_mask[t*8+c]` is set. A term with no selected column is 1.
- R4: Output o is the OR of every term t whose bit `cfg_or_mask[o*4+t]` is set. An output with no selected term is 0.
- R5: Both masks are captured at a rising clock edge where `cfg_we` is 1, and they affect the outputs only after that edge. Mask inputs presented while `cfg_we` is 0 change nothing.
- R6: Reset clears both stored masks, so every output is 0 for every input value until a write occurs.
- R7: One product term that selects columns 1 and 2 of pair 0 (AND mask 0x06) yields the equivalence of a and b, which is 1 when a equals b.
- R8: The two-term function Z = (~a|b)(c|d) + (~a|~b)(~c|d), with pair 1 giving c = `din[3]` and d = `din[2]`, is built from terms with AND masks 0x14 and 0x48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 4 | Binary inputs, two per pair |
| cfg_we | input | 1 | Write enable for both planes |
| cfg_and_mask | input | 32 | AND-plane mask, 8 column bits per term |
| cfg_or_mask | input | 8 | OR-plane mask, 4 term bits per output |
| func_out | output | 2 | Programmed binary functions |

## Verification
On every cycle, the in-line assertions check the following: each pair has exactly three active columns, an empty term evaluates to 1, an unused output stays 0, and the stored masks follow the write port and hold without it. Whether a programmed function matches its intended truth table can only be shown by the bench's scenarios. These cover random masks against a reference model, the equivalence and two-term examples, the cleared state after reset, and the cycle in which a write takes effect.

// File: rtl/pla_pkg.sv
package pla_pkg;
   localparam int BITS_PER_PAIR = 2;
   localparam int COLS_PER_PAIR = 4;
endpackage

// File: rtl/pla_pair_dec.sv
module pla_pair_dec
   import pla_pkg::*;
#(
   parameter int NUM_PAIRS = 2,
   localparam int IN_W  = NUM_PAIRS * BITS_PER_PAIR,
   localparam int COL_W = NUM_PAIRS * COLS_PER_PAIR
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IN_W-1:0]  pair_in,
   output logic [COL_W-1:0] col_out
);
   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      logic [1:0] val;
      assign val = pair_in[p*BITS_PER_PAIR +: BITS_PER_PAIR];   // R1: {a,b} = 2a+b
      for (genvar k = 0; k < COLS_PER_PAIR; k++) begin : g_col
         assign col_out[p*COLS_PER_PAIR + k] = (val != 2'(k));
      end
      AST_THREE_COLS: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(col_out[p*COLS_PER_PAIR +: COLS_PER_PAIR]) == 3); // R2
   end
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
   parameter int NUM_COLS  = 8,
   parameter int NUM_TERMS = 4,
   localparam int MASK_W   = NUM_COLS * NUM_TERMS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_COLS-1:0]  cols,
   input  logic [MASK_W-1:0]    and_mask,
   output logic [NUM_TERMS-1:0] terms
);
   for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
      logic [NUM_COLS-1:0] sel;
      assign sel      = and_mask[t*NUM_COLS +: NUM_COLS];
      assign terms[t] = &(cols | ~sel);
      AST_EMPTY_TERM: assert property (@(posedge clk) disable iff (!rst_n)
         (sel == '0) |-> terms[t]); // R3
   end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
   parameter int NUM_TERMS = 4,
   parameter int NUM_OUTS  = 2,
   localparam int MASK_W   = NUM_TERMS * NUM_OUTS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_TERMS-1:0] terms,
   input  logic [MASK_W-1:0]    or_mask,
   output logic [NUM_OUTS-1:0]  outs
);
   for (genvar o = 0; o < NUM_OUTS; o++) begin : g_out
      logic [NUM_TERMS-1:0] sel;
      assign sel     = or_mask[o*NUM_TERMS +: NUM_TERMS];
      assign outs[o] = |(terms & sel);
      AST_EMPTY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
         (sel == '0) |-> !outs[o]); // R4
   end
endmodule

// File: rtl/pla_cfg_regs.sv
module pla_cfg_regs #(
   parameter int AND_W = 32,
   parameter int OR_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AND_W-1:0] and_d,
   input  logic [OR_W-1:0]  or_d,
   output logic [AND_W-1:0] and_q,
   output logic [OR_W-1:0]  or_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         and_q <= '0;
         or_q  <= '0;
      end else if (we) begin
         and_q <= and_d;
         or_q  <= or_d;
      end
   end

   AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (and_q == $past(and_d)) && (or_q == $past(or_d))); // R5
   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(and_q) && $stable(or_q)); // R5
endmodule

// File: rtl/pairdec_pla.sv
module pairdec_pla
   import pla_pkg::*;
#(
   parameter int NUM_PAIRS = 2,
   parameter int NUM_TERMS = 4,
   parameter int NUM_OUTS  = 2,
   parameter bit OUT_REG   = 1'b0,
   localparam int IN_W     = NUM_PAIRS * BITS_PER_PAIR,
   localparam int NUM_COLS = NUM_PAIRS * COLS_PER_PAIR,
   localparam int AND_W    = NUM_COLS * NUM_TERMS,
   localparam int OR_W     = NUM_TERMS * NUM_OUTS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [IN_W-1:0]     din,
   input  logic                cfg_we,
   input  logic [AND_W-1:0]    cfg_and_mask,
   input  logic [OR_W-1:0]     cfg_or_mask,
   output logic [NUM_OUTS-1:0] func_out
);
   if (NUM_PAIRS < 1) begin : g_bad_pairs
      $error("pairdec_pla: NUM_PAIRS must be at least 1");
   end
   if (NUM_TERMS < 1) begin : g_bad_terms
      $error("pairdec_pla: NUM_TERMS must be at least 1");
   end
   if (NUM_OUTS < 1) begin : g_bad_outs
      $error("pairdec_pla: NUM_OUTS must be at least 1");
   end

   logic [AND_W-1:0]    and_q;
   logic [OR_W-1:0]     or_q;
   logic [NUM_COLS-1:0] cols;
   logic [NUM_TERMS-1:0] terms;
   logic [NUM_OUTS-1:0] outs_c;

   pla_cfg_regs #(.AND_W(AND_W), .OR_W(OR_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we),
      .and_d(cfg_and_mask), .or_d(cfg_or_mask),
      .and_q(and_q), .or_q(or_q)
   );

   pla_pair_dec #(.NUM_PAIRS(NUM_PAIRS)) u_dec (
      .clk(clk), .rst_n(rst_n), .pair_in(din), .col_out(cols)
   );

   pla_and_plane #(.NUM_COLS(NUM_COLS), .NUM_TERMS(NUM_TERMS)) u_and (
      .clk(clk), .rst_n(rst_n), .cols(cols), .and_mask(and_q), .terms(terms)
   );

   pla_or_plane #(.NUM_TERMS(NUM_TERMS), .NUM_OUTS(NUM_OUTS)) u_or (
      .clk(clk), .rst_n(rst_n), .terms(terms), .or_mask(or_q), .outs(outs_c)
   );

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk) begin
         if (!rst_n) func_out <= '0;
         else        func_out <= outs_c;
      end
   end else begin : g_out_comb
      assign func_out = outs_c;
   end

   AST_CLEARED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (or_q == '0) |-> (outs_c == '0)); // R6
endmodule

// File: tb/pairdec_pla_tb.sv
module pairdec_pla_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  din = '0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_and_mask = '0;
   logic [7:0]  cfg_or_mask = '0;
   logic [1:0]  func_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] cur_and = '0;
   logic [7:0]  cur_or = '0;

   always #2 clk = ~clk;

   pairdec_pla u_dut (
      .clk(clk), .rst_n(rst_n), .din(din), .cfg_we(cfg_we),
      .cfg_and_mask(cfg_and_mask), .cfg_or_mask(cfg_or_mask),
      .func_out(func_out)
   );

   function automatic logic [1:0] model(input logic [3:0] d, input logic [31:0] am,
                                        input logic [7:0] om);
      logic [7:0] c;
      logic [3:0] t;
      logic [1:0] r;
      for (int p = 0; p < 2; p++) begin
         int x = 2 * int'(d[2*p+1]) + int'(d[2*p]);
         for (int k = 0; k < 4; k++) c[4*p+k] = (x != k);
      end
      for (int i = 0; i < 4; i++) begin
         t[i] = 1'b1;
         for (int j = 0; j < 8; j++) if (am[i*8+j] && !c[j]) t[i] = 1'b0;
      end
      for (int o = 0; o < 2; o++) begin
         r[o] = 1'b0;
         for (int i = 0; i < 4; i++) if (om[o*4+i] && t[i]) r[o] = 1'b1;
      end
      return r;
   endfunction

   task automatic check(input string req, input logic [1:0] exp);
      checks++;
      if (func_out !== exp) begin
         errors++;
         $display("FAIL %s din=%b actual=%b expected=%b", req, din, func_out, exp);
      end
   endtask

   task automatic write_cfg(input logic [31:0] am, input logic [7:0] om);
      @(negedge clk);
      cfg_and_mask = am; cfg_or_mask = om; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
      cur_and = am; cur_or = om;
   endtask

   task automatic apply(input logic [3:0] d);
      @(negedge clk);
      din = d;
      #1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R6: cleared masks give 0 for every input
      for (int v = 0; v < 16; v++) begin
         apply(4'(v));
         check("R6", 2'b00);
      end
      // R2 / R1: single-column terms expose each column on output 0
      for (int c = 0; c < 8; c++) begin
         write_cfg(32'(1) << c, 8'h01);
         for (int v = 0; v < 16; v++) begin
            apply(4'(v));
            check((c < 4) ? "R2 pair0 (R1 value)" : "R2 pair1 (R1 value)",
                  model(4'(v), cur_and, cur_or));
         end
      end
      // R3: empty term is 1; R4: output with no term stays 0
      write_cfg(32'h0000_0000, 8'h01);
      for (int v = 0; v < 16; v += 5) begin
         apply(4'(v));
         check("R3 empty term / R4 unused output", 2'b01);
      end
      // R7: equivalence from columns 1 and 2 of pair 0
      write_cfg(32'h0000_0006, 8'h01);
      for (int v = 0; v < 4; v++) begin
         apply(4'(v));
         check("R7", {1'b0, (v == 0 || v == 3)});
      end
      // R8: Z = T1 + T2 on output 1
      write_cfg(32'h0000_4814, 8'h30);
      for (int v = 0; v < 16; v++) begin
         logic a, b, c2, d2, z;
         a = v[1]; b = v[0]; c2 = v[3]; d2 = v[2];
         z = ((~a | b) & (c2 | d2)) | ((~a | ~b) & (~c2 | d2));
         apply(4'(v));
         check("R8", {z, 1'b0});
      end
      // R5: new mask presented with write enable has no effect before the edge
      apply(4'b0000);
      @(negedge clk);
      cfg_and_mask = 32'h0; cfg_or_mask = 8'hFF; cfg_we = 1'b1;
      #1;
      check("R5 before edge", model(4'b0000, cur_and, cur_or));
      @(negedge clk);
      cfg_we = 1'b0;
      cur_and = 32'h0; cur_or = 8'hFF;
      #1;
      check("R5 after edge", 2'b11);
      // R5: mask inputs without write enable are ignored
      @(negedge clk);
      cfg_and_mask = 32'hFFFF_FFFF; cfg_or_mask = 8'h00;
      @(negedge clk);
      @(negedge clk);
      #1;
      check("R5 ignored without write", 2'b11);
      // Random masks and inputs, R3 and R4 against the model
      void'($urandom(32'd1234));
      for (int n = 0; n < 150; n++) begin
         logic [31:0] am;
         logic [7:0] om;
         am = $urandom & $urandom;
         om = 8'($urandom);
         write_cfg(am, om);
         for (int k = 0; k < 4; k++) begin
            apply(4'($urandom));
            check("R3/R4 random", model(din, cur_and, cur_or));
         end
      end
      // R6: reset again clears programmed masks
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      apply(4'b1010);
      check("R6 after re-reset", 2'b00);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule